// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address. It reads one entry from a linear page table held in memory. The upper bits of the virtual address form the page number. The low bits are the page offset, and they pass through unchanged. The walker adds four times the page number to a base register and issues one read on a simple request/response memory port.

When the entry returns, the walker checks it. A missing valid mark, a page that is not resident, or an access that the page's permissions forbid all end the walk with a fault code. Otherwise the walker builds the physical address from the entry's frame number and the offset. If the access changes the entry's reference or dirty marks, the walker writes the updated entry back before it responds.

Only one translation runs at a time. Privileged software may reload the base register only while the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle with `req_ready` high, `mem_req` low and `resp_valid` low. The table base is zero, so the first walk for page 2 reads address 8.
- R2: Each translation issues exactly one read, at address base + page number × 4. The page number is `req_vaddr[VA_W-1:OFF_W]`.
- R3: A successful translation returns the entry's frame number concatenated with the unchanged offset `req_vaddr[OFF_W-1:0]`. With 4 KB pages, page 1 at offset 5 mapped to frame 7 gives 0x7005.
- R4: Entry layout: bit 0 is valid, bit 1 is present, bit 2 is readable, bit 3 is writable, bit 4 is referenced, bit 5 is dirty. The frame number sits at `[FRAME_LSB +: PFN_W]`, which is bits [31:12] by default.
- R5: An entry with bit 0 clear yields fault code 1. This code takes priority over every other check.
- R6: A valid entry with bit 1 clear yields fault code 2.
- R7: A valid, present entry yields fault code 3 in two cases: a write when bit 3 is clear, or a read when bit 2 is clear.
- R8: A fault-free access writes the entry back to the same address with bit 4 set, and also with bit 5 set on a write. It does so only if one of those bits changes. A faulting access never writes.
- R9: A base write takes effect only when `priv` is high and the walker is idle. An unprivileged write, or a write during a walk, leaves the base unchanged.
- R10: A privileged base write in the same cycle that a request is accepted is applied, and that walk already uses the new base.
- R11: `resp_valid` lasts one cycle. With a nonzero fault code `resp_paddr` is zero. `req_ready` stays low from acceptance until the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request, taken when `req_ready` is high |
| req_vaddr | input | VA_W | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_ready | output | 1 | Walker idle |
| priv | input | 1 | Privileged mode |
| base_we | input | 1 | Base register write strobe |
| base_wdata | input | AW | New table base |
| mem_req | output | 1 | Memory access strobe, one cycle |
| mem_we | output | 1 | 1 = entry write-back, 0 = entry read |
| mem_addr | output | AW | Entry address |
| mem_wdata | output | 32 | Updated entry |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry read data |
| resp_valid | output | 1 | Translation done, one cycle |
| resp_paddr | output | PFN_W+OFF_W | Physical address, zero on fault |
| resp_fault | output | 2 | 0 ok, 1 invalid, 2 not present, 3 protection |

## Verification
Two events can fall in the same cycle here: a request being accepted and a privileged base reload. The bench raises `req_valid` and `base_we` on the same edge while the walker is idle. It then checks that the address on the entry read uses the new base, and that a later walk uses the new base as well. The bench also attempts a reload one cycle into a running walk. The read address of the current walk and of the next walk show that this reload was dropped.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W      = 32,
  parameter int OFF_W     = 12,
  parameter int PFN_W     = 20,
  parameter int AW        = 32,
  parameter int FRAME_LSB = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_vaddr,
  input  logic                   req_write,
  output logic                   req_ready,
  input  logic                   priv,
  input  logic                   base_we,
  input  logic [AW-1:0]          base_wdata,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [AW-1:0]          mem_addr,
  output logic [31:0]            mem_wdata,
  input  logic                   mem_rvalid,
  input  logic [31:0]            mem_rdata,
  output logic                   resp_valid,
  output logic [PFN_W+OFF_W-1:0] resp_paddr,
  output logic [1:0]             resp_fault
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PA_W  = PFN_W + OFF_W;
  localparam int B_V = 0, B_P = 1, B_R = 2, B_W = 3, B_REF = 4, B_D = 5;

  typedef enum logic [2:0] {IDLE, RD, WAIT, CHK, WB, RESP} st_t;
  st_t state;

  logic [VA_W-1:0] va_q;
  logic            wr_q;
  logic [31:0]     pte_q;
  logic [AW-1:0]   base;
  logic [1:0]      fault_q, fault_c;
  logic [PA_W-1:0] pa_q;
  logic            need_wb;
  logic [VPN_W-1:0] vpn;

  assign vpn     = va_q[VA_W-1:OFF_W];
  assign need_wb = !pte_q[B_REF] || (wr_q && !pte_q[B_D]);

  always_comb begin
    if (!pte_q[B_V])                               fault_c = 2'd1;
    else if (!pte_q[B_P])                          fault_c = 2'd2;
    else if (wr_q ? !pte_q[B_W] : !pte_q[B_R])     fault_c = 2'd3;
    else                                           fault_c = 2'd0;
  end

  assign req_ready  = state == IDLE;
  assign mem_req    = state == RD || state == WB;
  assign mem_we     = state == WB;
  assign mem_addr   = base + {{(AW-VPN_W-2){1'b0}}, vpn, 2'b00};
  assign mem_wdata  = pte_q | (32'd1 << B_REF) | (wr_q ? (32'd1 << B_D) : 32'd0);
  assign resp_valid = state == RESP;
  assign resp_paddr = pa_q;
  assign resp_fault = fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      pte_q   <= '0;
      base    <= '0;
      fault_q <= '0;
      pa_q    <= '0;
    end else begin
      if (base_we && priv && state == IDLE) base <= base_wdata;
      case (state)
        IDLE: if (req_valid) begin
          va_q  <= req_vaddr;
          wr_q  <= req_write;
          state <= RD;
        end
        RD:   state <= WAIT;
        WAIT: if (mem_rvalid) begin
          pte_q <= mem_rdata;
          state <= CHK;
        end
        CHK: begin
          fault_q <= fault_c;
          pa_q    <= (fault_c == 2'd0) ? {pte_q[FRAME_LSB +: PFN_W], va_q[OFF_W-1:0]} : '0;
          state   <= (fault_c == 2'd0 && need_wb) ? WB : RESP;
        end
        WB:   state <= RESP;
        default: state <= IDLE;
      endcase
    end
  end

  p_base_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != IDLE) |=> $stable(base));
  p_resp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  p_fault_zero_pa_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault != 2'd0) |-> resp_paddr == '0);
  p_wb_ref_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[B_REF]);
  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);
  p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic req_valid = 0, req_write = 0, priv = 0, base_we = 0;
  logic [31:0] req_vaddr = 0, base_wdata = 0;
  logic req_ready, mem_req, mem_we, mem_rvalid, resp_valid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, resp_paddr;
  logic [1:0] resp_fault;

  pt_walker u0 (.clk, .rst_n, .req_valid, .req_vaddr, .req_write, .req_ready, .priv,
    .base_we, .base_wdata, .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rvalid,
    .mem_rdata, .resp_valid, .resp_paddr, .resp_fault);

  logic [31:0] mem [0:255];
  logic [31:0] raddr_l = 0, last_raddr = 0, last_waddr = 0, last_wdata = 0;
  int rd_cnt = 0, wr_cnt = 0, lat = 0;
  int nchk = 0, nfail = 0;

  assign mem_rvalid = lat == 1;
  assign mem_rdata  = mem[raddr_l[9:2]];

  always @(posedge clk) begin
    if (mem_req && !mem_we) begin
      raddr_l <= mem_addr; last_raddr <= mem_addr; rd_cnt <= rd_cnt + 1; lat <= 3;
    end else if (lat != 0) lat <= lat - 1;
    if (mem_req && mem_we) begin
      mem[mem_addr[9:2]] <= mem_wdata;
      last_waddr <= mem_addr; last_wdata <= mem_wdata; wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic wr, input logic bw,
                      input logic [31:0] bval, output logic [31:0] pa, output logic [1:0] f);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_write = wr;
    base_we = bw; base_wdata = bval; priv = bw;
    @(negedge clk);
    req_valid = 0; base_we = 0; priv = 0;
    while (!resp_valid) @(negedge clk);
    pa = resp_paddr; f = resp_fault;
    @(negedge clk);
    chk("R11 pulse", {31'd0, resp_valid}, 32'd0);
  endtask

  task automatic set_base(input logic [31:0] v, input logic p);
    @(negedge clk);
    base_we = 1; base_wdata = v; priv = p;
    @(negedge clk);
    base_we = 0; priv = 0;
  endtask

  task automatic t_reset;
    logic [31:0] pa; logic [1:0] f;
    chk("R1 ready", {31'd0, req_ready}, 32'd1);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 resp", {31'd0, resp_valid}, 32'd0);
    mem[2] = 32'h0000_9017;
    walk(32'h0000_2abc, 0, 0, 0, pa, f);
    chk("R1 base zero addr", last_raddr, 32'd8);
    chk("R3 pa", pa, 32'h0000_9abc);
  endtask

  task automatic t_read_ok;
    logic [31:0] pa; logic [1:0] f; int r0, w0;
    set_base(32'h100, 1);
    mem[32'h41] = 32'h0000_7007;
    r0 = rd_cnt; w0 = wr_cnt;
    walk(32'h0000_1005, 0, 0, 0, pa, f);
    chk("R2 addr", last_raddr, 32'h104);
    chk("R2 one read", rd_cnt - r0, 1);
    chk("R3 pa", pa, 32'h7005);
    chk("R3 fault", {30'd0, f}, 0);
    chk("R8 ref wb count", wr_cnt - w0, 1);
    chk("R8 ref wb data", last_wdata, 32'h7017);
    chk("R8 wb addr", last_waddr, 32'h104);
    w0 = wr_cnt;
    walk(32'h0000_1fff, 0, 0, 0, pa, f);
    chk("R8 no change no wb", wr_cnt - w0, 0);
    chk("R4 pa", pa, 32'h7fff);
  endtask

  task automatic t_write_ok;
    logic [31:0] pa; logic [1:0] f; int w0;
    mem[32'h43] = 32'habcd_e01f;
    w0 = wr_cnt;
    walk(32'h0000_3010, 1, 0, 0, pa, f);
    chk("R4 frame", pa, 32'habcd_e010);
    chk("R8 dirty wb", last_wdata, 32'habcd_e03f);
    chk("R8 dirty count", wr_cnt - w0, 1);
    w0 = wr_cnt;
    walk(32'h0000_3020, 1, 0, 0, pa, f);
    chk("R8 dirty already", wr_cnt - w0, 0);
  endtask

  task automatic t_faults;
    logic [31:0] pa; logic [1:0] f; int w0;
    mem[32'h44] = 32'h0000_5000;
    mem[32'h45] = 32'h0000_5005;
    mem[32'h46] = 32'h0000_5017;
    mem[32'h47] = 32'h0000_500b;
    mem[32'h48] = 32'h0000_503e;
    w0 = wr_cnt;
    walk(32'h0000_4000, 0, 0, 0, pa, f);
    chk("R5 invalid", {30'd0, f}, 1);
    chk("R11 pa zero", pa, 0);
    walk(32'h0000_5000, 0, 0, 0, pa, f);
    chk("R6 not present", {30'd0, f}, 2);
    walk(32'h0000_6000, 1, 0, 0, pa, f);
    chk("R7 write ro", {30'd0, f}, 3);
    walk(32'h0000_7000, 0, 0, 0, pa, f);
    chk("R7 read wo", {30'd0, f}, 3);
    walk(32'h0000_8000, 1, 0, 0, pa, f);
    chk("R5 priority", {30'd0, f}, 1);
    chk("R8 no wb on fault", wr_cnt - w0, 0);
  endtask

  task automatic t_base_ctl;
    logic [31:0] pa; logic [1:0] f;
    set_base(32'h300, 0);
    walk(32'h0000_1000, 0, 0, 0, pa, f);
    chk("R9 unpriv ignored", last_raddr, 32'h104);
    @(negedge clk);
    req_valid = 1; req_vaddr = 32'h0000_1000; req_write = 0;
    @(negedge clk);
    req_valid = 0; base_we = 1; priv = 1; base_wdata = 32'h300;
    @(negedge clk);
    base_we = 0; priv = 0;
    while (!resp_valid) @(negedge clk);
    @(negedge clk);
    chk("R9 busy walk addr", last_raddr, 32'h104);
    walk(32'h0000_1000, 0, 0, 0, pa, f);
    chk("R9 busy write dropped", last_raddr, 32'h104);
    mem[32'h82] = 32'h0000_2017;
    walk(32'h0000_2044, 0, 1, 32'h200, pa, f);
    chk("R10 same cycle addr", last_raddr, 32'h208);
    chk("R10 pa", pa, 32'h2044);
    walk(32'h0000_2000, 0, 0, 0, pa, f);
    chk("R10 base kept", last_raddr, 32'h208);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_read_ok;
    t_write_ok;
    t_faults;
    t_base_ctl;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule